// File: doc/BRIEF.md
# Shared-Memory Exclusive Access Monitor

This block sits at a memory port that several masters share. It keeps, for each master, one tagged block address and an armed/open flag. Upstream arbitration presents at most one request per cycle, marked with the issuing master's index. A load-exclusive arms the issuer's entry on the addressed block. A store-exclusive that has already passed the issuer's local monitor is checked here. The block grants or refuses the memory write in the same cycle and returns a pass/fail status bit.

Any write that reaches memory disarms the entries of every other master tagged on that block. Both ordinary writes and granted store-exclusives count. So when another observer writes in between, a load-exclusive/store-exclusive pair fails and must be retried. Tags are compared at block granularity, and the block size is a power-of-two parameter of at most 2048 bytes. A per-master force-open input lets system software drop a master's reservation on a context switch.

Top module: `xmon_global`

## Requirements
- R1: Addresses are compared at block granularity. Two addresses match when they agree in every bit above log2(BLK_BYTES), whatever their offset inside the block.
- R2: A load-exclusive (req_kind 2'b01) from master m arms m's entry and records the block of req_addr as m's tag.
- R3: A store-exclusive (req_kind 2'b10) raises sx_resp in the same cycle. It is granted only when the issuer's entry is armed and its tag matches the request's block.
  - Granted: mem_we=1 and sx_fail=0.
  - Refused: mem_we=0 and sx_fail=1.
- R4: A write that commits (mem_we=1) disarms every other master whose tag matches its block. The write may be an ordinary write or a granted store-exclusive.
- R5: A master's ordinary writes never change its own entry. A committed write to a different block leaves every entry unchanged.
- R6: After any store-exclusive, granted or refused, the issuer's entry is open. A second store-exclusive without a new load-exclusive is therefore refused.
- R7: When requests to one block follow each other, the first granted store-exclusive disarms the other masters before the next request is judged.
- R8: Reset leaves every entry open.
- R9: force_open[m] opens m's entry at the next edge and takes priority over a load-exclusive from m in the same cycle.
- R10: A cycle with req_valid low, or with req_kind 2'b11, produces mem_we=0 and sx_resp=0 and changes no entry.
- R11: An ordinary write (req_kind 2'b00) always gives mem_we=1 in the same cycle with sx_resp=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 00 write, 01 load-exclusive, 10 store-exclusive, 11 none |
| req_id | input | IDW | Issuing master index |
| req_addr | input | AW | Byte address of the request |
| force_open | input | N | Per-master reservation drop |
| mem_we | output | 1 | Write may commit to memory this cycle |
| sx_resp | output | 1 | Store-exclusive status is valid |
| sx_fail | output | 1 | Store-exclusive status: 1 refused, 0 granted |

## Verification
A wrong internal entry shows at the ports only when that master next issues a store-exclusive to the tagged block. In that cycle mem_we and sx_fail take the opposite values. So the bench follows each disturbing action with a store-exclusive from the affected master in the very next request. The disturbing actions are a foreign write, an own write, a force-open and a reserved request. A long pseudo-random sequence, confined to two blocks, then makes stale or missing disarms appear within a few requests.

// File: rtl/xmon_global.sv
module xmon_global #(
  parameter int N         = 4,
  parameter int AW        = 32,
  parameter int BLK_BYTES = 64,   // power of two, at most 2048
  localparam int IDW = (N > 1) ? $clog2(N) : 1,
  localparam int OFS = $clog2(BLK_BYTES),
  localparam int TW  = AW - OFS
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic [1:0]     req_kind,
  input  logic [IDW-1:0] req_id,
  input  logic [AW-1:0]  req_addr,
  input  logic [N-1:0]   force_open,
  output logic           mem_we,
  output logic           sx_resp,
  output logic           sx_fail
);
  localparam logic [1:0] K_WR  = 2'b00;
  localparam logic [1:0] K_LDX = 2'b01;
  localparam logic [1:0] K_STX = 2'b10;

  logic [N-1:0]  excl;
  logic [TW-1:0] tag [N];

  wire [TW-1:0] req_tag = req_addr[AW-1:OFS];
  wire          id_ok   = 32'(req_id) < N;
  wire          is_wr   = req_valid && id_ok && req_kind == K_WR;
  wire          is_ldx  = req_valid && id_ok && req_kind == K_LDX;
  wire          is_stx  = req_valid && id_ok && req_kind == K_STX;
  wire          own_hit = id_ok && excl[req_id] && tag[req_id] == req_tag;

  assign sx_resp = is_stx;
  assign sx_fail = is_stx && !own_hit;
  assign mem_we  = is_wr || (is_stx && own_hit);

  for (genvar i = 0; i < N; i++) begin : g_ent
    wire mine = req_id == IDW'(i);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        excl[i] <= 1'b0;
        tag[i]  <= '0;
      end else if (force_open[i]) begin
        excl[i] <= 1'b0;
      end else if (mine && is_ldx) begin
        excl[i] <= 1'b1;
        tag[i]  <= req_tag;
      end else if (mine && is_stx) begin
        excl[i] <= 1'b0;
      end else if (!mine && mem_we && tag[i] == req_tag) begin
        excl[i] <= 1'b0;
      end
    end
  end
endmodule

module xmon_global_chk #(
  parameter int N         = 4,
  parameter int AW        = 32,
  parameter int BLK_BYTES = 64,
  localparam int IDW = (N > 1) ? $clog2(N) : 1,
  localparam int OFS = $clog2(BLK_BYTES),
  localparam int TW  = AW - OFS
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic [1:0]     req_kind,
  input logic [IDW-1:0] req_id,
  input logic [AW-1:0]  req_addr,
  input logic [N-1:0]   force_open,
  input logic           mem_we,
  input logic           sx_resp,
  input logic           sx_fail,
  input logic [N-1:0]   excl,
  input logic [TW-1:0]  tag [N]
);
  // R8
  reset_open_chk: assert property (@(posedge clk) $rose(rst_n) |-> excl == '0);

  // R3
  stx_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sx_resp |-> (mem_we == !sx_fail));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid || req_kind == 2'b11) |-> (!mem_we && !sx_resp));

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R2
    ldx_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == 2'b01 && req_id == IDW'(i) && !force_open[i])
      |=> (excl[i] && tag[i] == $past(req_addr[AW-1:OFS])));
    // R6
    stx_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == 2'b10 && req_id == IDW'(i)) |=> !excl[i]);
    // R4
    cross_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && req_id != IDW'(i) && tag[i] == req_addr[AW-1:OFS]) |=> !excl[i]);
    // R9
    force_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      force_open[i] |=> !excl[i]);
  end
endmodule

bind xmon_global xmon_global_chk #(.N(N), .AW(AW), .BLK_BYTES(BLK_BYTES)) u_chk (.*);

// File: tb/sim_xmon_global.sv
module sim_xmon_global;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4, AW = 12, BLK = 16, OFS = 4;

  logic clk = 0, rst_n = 0, req_valid = 0;
  logic [1:0] req_kind = 2'b11;
  logic [1:0] req_id = 0;
  logic [AW-1:0] req_addr = 0;
  logic [N-1:0] force_open = 0;
  logic mem_we, sx_resp, sx_fail;

  always #(CLK_PERIOD/2) clk = ~clk;

  xmon_global #(.N(N), .AW(AW), .BLK_BYTES(BLK)) u0 (.*);

  int tests = 0, fails = 0;
  bit done = 0;
  bit m_ex [N];
  logic [AW-OFS-1:0] m_tag [N];

  task automatic step(input logic v, input logic [1:0] k, input int id,
                      input logic [AW-1:0] a, input logic [N-1:0] fo, input string rq);
    logic hit, we, rs, fl;
    @(negedge clk);
    req_valid = v; req_kind = k; req_id = 2'(id); req_addr = a; force_open = fo;
    #1;
    hit = m_ex[id] && m_tag[id] == a[AW-1:OFS];
    rs  = v && k == 2'b10;
    we  = (v && k == 2'b00) || (rs && hit);
    fl  = rs && !hit;
    tests++;
    if ({mem_we, sx_resp, sx_fail} !== {we, rs, fl}) begin
      fails++;
      $display("FAIL %s: {we,resp,fail} got %b expected %b", rq,
               {mem_we, sx_resp, sx_fail}, {we, rs, fl});
    end
    for (int i = 0; i < N; i++) begin
      if (fo[i]) m_ex[i] = 0;
      else if (v && id == i) begin
        if (k == 2'b01) begin m_ex[i] = 1; m_tag[i] = a[AW-1:OFS]; end
        else if (k == 2'b10) m_ex[i] = 0;
      end else if (we && m_tag[i] == a[AW-1:OFS]) m_ex[i] = 0;
    end
  endtask

  localparam logic [1:0] WR = 2'b00, LD = 2'b01, SX = 2'b10, NO = 2'b11;

  initial begin
    for (int i = 0; i < N; i++) begin m_ex[i] = 0; m_tag[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R8: each master refused right after reset
    for (int m = 0; m < N; m++) step(1, SX, m, 12'h100, 0, "R8");
    for (int a = 0; a < N; a++) begin
      // R2 R3 R1: arm then store at another offset of the same block
      step(1, LD, a, 12'h230, 0, "R2");
      step(1, SX, a, 12'h23C, 0, "R1");
      // R6: second store-exclusive refused
      step(1, SX, a, 12'h230, 0, "R6");
      // R3: block mismatch refused
      step(1, LD, a, 12'h230, 0, "R2");
      step(1, SX, a, 12'h240, 0, "R3");
      // R5: own write does not disarm
      step(1, LD, a, 12'h230, 0, "R2");
      step(1, WR, a, 12'h234, 0, "R11");
      step(1, SX, a, 12'h230, 0, "R5");
      // R9: force open, and force beats simultaneous load-exclusive
      step(1, LD, a, 12'h230, 0, "R2");
      step(0, NO, a, 12'h230, 4'(1 << a), "R9");
      step(1, SX, a, 12'h230, 0, "R9");
      step(1, LD, a, 12'h230, 4'(1 << a), "R9");
      step(1, SX, a, 12'h230, 0, "R9");
      // R10: idle and reserved kind leave entry armed
      step(1, LD, a, 12'h230, 0, "R2");
      step(0, WR, (a + 1) % N, 12'h230, 0, "R10");
      step(1, NO, (a + 1) % N, 12'h230, 0, "R10");
      step(1, SX, a, 12'h230, 0, "R10");
      for (int b = 0; b < N; b++) if (b != a) begin
        // R4: foreign write to same block disarms
        step(1, LD, a, 12'h3A0, 0, "R2");
        step(1, WR, b, 12'h3AF, 0, "R11");
        step(1, SX, a, 12'h3A0, 0, "R4");
        // R5: foreign write elsewhere does not
        step(1, LD, a, 12'h3A0, 0, "R2");
        step(1, WR, b, 12'h3B0, 0, "R5");
        step(1, SX, a, 12'h3A0, 0, "R5");
        // R7: both armed, first grant wins, second refused
        step(1, LD, a, 12'h3A0, 0, "R2");
        step(1, LD, b, 12'h3A4, 0, "R2");
        step(1, SX, b, 12'h3A4, 0, "R7");
        step(1, SX, a, 12'h3A0, 0, "R7");
      end
    end
    // random sweep over two blocks, checked against the model
    begin
      logic [15:0] r = 16'hACE1;
      for (int s = 0; s < 4000; s++) begin
        r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
        step(r[14:12] != 0, r[1:0], int'(r[3:2]), {7'b0, r[4], r[11:8]},
             (r[7:5] == 0) ? 4'(1 << r[9:8]) : 4'b0, "RND");
      end
    end
    step(0, NO, 0, 0, 0, "R10");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule